// File: doc/BRIEF.md
# Shared Register Space Arbiter with Retry Flag

This block guards one processing engine's local control and status register space. Two ports reach that space: a host port, driven from outside the engine, and an engine port, driven by the engine itself. Only one access can be served per clock. When both ports ask in the same cycle, the engine port always wins. The host access is then thrown away rather than held. A one-bit retry flag records that the loss happened, and the host can read it back.

Host addresses carry an engine index above a 10-bit byte offset, so each engine owns a 1 KB window. The block answers only host accesses whose index matches its own. Behind the arbiter sits a word-wide storage array that models the registers. The retry flag is not kept in that array: it lives at byte offset 0x180 of the window, in bit 0.

After each host access, software reads the flag. If the flag reads 1, software repeats the access until the flag reads 0. Both ports use a plain request/response scheme with no back-pressure. A request is a single-cycle `valid` pulse. Its response, an `ack` pulse together with read data, appears in the following cycle.

Top module: `csr_collide_arbiter`

## Requirements
- R1: After reset, both `ack` outputs are 0 and the retry flag reads 0.
- R2: A host access whose address bits above the offset equal `ENGINE_ID` is answered with `host_ack` one cycle later. A host write stores its data, and a later host read of the same offset returns that data.
- R3: A host access with any other engine index gets no `host_ack` and changes no stored word.
- R4: Every engine access is answered with `eng_ack` one cycle later and is always performed, whether or not the host asks in the same cycle.
- R5: A host access to a non-flag offset made in the same cycle as any engine access is not performed. If it is a write, the stored word keeps its old value.
- R6: Such a colliding host access sets the retry flag. A host read of offset 0x180 then returns 1 in bit 0 and 0 in all other bits.
- R7: A host access to a non-flag offset made while the engine port is idle clears the retry flag.
- R8: A host access to offset 0x180 never collides, even when the engine is active. A read returns the current flag. Neither a read nor a write there changes the flag.
- R9: A dropped host read is still acknowledged, and its read data is all zeros.
- R10: An engine read of offset 0x180 returns the flag in bit 0. An engine write to offset 0x180 has no effect.
- R11: Stored words are addressed by offset bits 9 to 2. Offsets that differ only in bits 1 to 0 reach the same word, except offset 0x180 itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request pulse |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ENG_IDX_W+OFS_W | Engine index above byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_ack | output | 1 | Host response, one cycle after request |
| host_rdata | output | DATA_W | Host read data, valid with host_ack |
| eng_valid | input | 1 | Engine request pulse |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_offset | input | OFS_W | Engine byte offset |
| eng_wdata | input | DATA_W | Engine write data |
| eng_ack | output | 1 | Engine response, one cycle after request |
| eng_rdata | output | DATA_W | Engine read data, valid with eng_ack |

## Verification
The bench builds the block with a 3-bit engine index and `ENGINE_ID` set to 5, so both a matching window and a foreign window (index 2) fit in a short address. With the default 10-bit offset and 32-bit data, the flag offset 0x180 and the byte-lane aliasing of its neighbours can be reached directly. The tests place host and engine requests in the same cycle in every combination: write against write, read against read, flag access against storage access, and foreign access against storage access. Each test then reads the flag back to confirm it was set or cleared.

// File: rtl/csr_arb_pkg.sv
package csr_arb_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_MEM  = 2'd1,
    RSP_FLAG = 2'd2,
    RSP_DROP = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/csr_offset_decode.sv
module csr_offset_decode #(
  parameter int OFS_W = 10,
  parameter logic [OFS_W-1:0] FLAG_OFS = 10'h180,
  localparam int IDX_W = OFS_W - 2
) (
  input  logic [OFS_W-1:0] offset,
  output logic             is_flag,
  output logic [IDX_W-1:0] word_idx
);
  // The flag matches on the exact byte offset; storage is word addressed.
  assign is_flag  = (offset == FLAG_OFS);
  assign word_idx = offset[OFS_W-1:2];
endmodule

// File: rtl/csr_port_arbiter.sv
module csr_port_arbiter
  import csr_arb_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = OFS_W - 2
) (
  input  logic              host_sel,
  input  logic              host_we,
  input  logic              host_flag,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wd,
  input  logic              eng_valid,
  input  logic              eng_we,
  input  logic              eng_flag,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wd,
  output logic              mem_en,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wd,
  output rsp_kind_e         host_kind,
  output rsp_kind_e         eng_kind,
  output logic              host_touch,
  output logic              collide
);
  logic eng_mem;
  logic host_mem;

  // A flag access never needs storage, so it never contends.
  assign host_touch = host_sel && !host_flag;
  assign collide    = host_touch && eng_valid;
  assign eng_mem    = eng_valid && !eng_flag;
  assign host_mem   = host_touch && !eng_valid;

  always_comb begin
    mem_en  = 1'b0;
    mem_we  = 1'b0;
    mem_idx = '0;
    mem_wd  = '0;
    if (eng_mem) begin
      mem_en  = 1'b1;
      mem_we  = eng_we;
      mem_idx = eng_idx;
      mem_wd  = eng_wd;
    end else if (host_mem) begin
      mem_en  = 1'b1;
      mem_we  = host_we;
      mem_idx = host_idx;
      mem_wd  = host_wd;
    end
  end

  always_comb begin
    if (!host_sel)      host_kind = RSP_IDLE;
    else if (host_flag) host_kind = RSP_FLAG;
    else if (collide)   host_kind = RSP_DROP;
    else                host_kind = RSP_MEM;

    if (!eng_valid)     eng_kind = RSP_IDLE;
    else if (eng_flag)  eng_kind = RSP_FLAG;
    else                eng_kind = RSP_MEM;
  end
endmodule

// File: rtl/csr_word_store.sv
module csr_word_store #(
  parameter int IDX_W = 8,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) words[idx] <= wd;
      rd <= words[idx];
    end
  end
endmodule

// File: rtl/csr_collide_arbiter.sv
module csr_collide_arbiter
  import csr_arb_pkg::*;
#(
  parameter int ENG_IDX_W = 5,
  parameter int ENGINE_ID = 3,
  parameter int OFS_W = 10,
  parameter int DATA_W = 32,
  parameter logic [OFS_W-1:0] FLAG_OFS = 10'h180,
  localparam int HA_W = ENG_IDX_W + OFS_W,
  localparam int IDX_W = OFS_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_valid,
  input  logic              eng_we,
  input  logic [OFS_W-1:0]  eng_offset,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_ack,
  output logic [DATA_W-1:0] eng_rdata
);
  logic              host_sel;
  logic              host_flag, eng_flag;
  logic [IDX_W-1:0]  host_idx, eng_idx;
  logic              mem_en, mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wd, mem_rd;
  rsp_kind_e         host_kind, eng_kind;
  rsp_kind_e         host_kind_q, eng_kind_q;
  logic              host_touch, collide;
  logic              flag_q, flag_snap_q;
  logic [DATA_W-1:0] flag_word;

  assign host_sel = host_valid &&
                    (host_addr[HA_W-1:OFS_W] == ENG_IDX_W'(ENGINE_ID));

  csr_offset_decode #(.OFS_W(OFS_W), .FLAG_OFS(FLAG_OFS)) host_dec_i (
    .offset(host_addr[OFS_W-1:0]), .is_flag(host_flag), .word_idx(host_idx)
  );

  csr_offset_decode #(.OFS_W(OFS_W), .FLAG_OFS(FLAG_OFS)) eng_dec_i (
    .offset(eng_offset), .is_flag(eng_flag), .word_idx(eng_idx)
  );

  csr_port_arbiter #(.OFS_W(OFS_W), .DATA_W(DATA_W)) arb_i (
    .host_sel(host_sel), .host_we(host_we), .host_flag(host_flag),
    .host_idx(host_idx), .host_wd(host_wdata),
    .eng_valid(eng_valid), .eng_we(eng_we), .eng_flag(eng_flag),
    .eng_idx(eng_idx), .eng_wd(eng_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_idx(mem_idx), .mem_wd(mem_wd),
    .host_kind(host_kind), .eng_kind(eng_kind),
    .host_touch(host_touch), .collide(collide)
  );

  csr_word_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .en(mem_en), .we(mem_we), .idx(mem_idx), .wd(mem_wd),
    .rd(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q      <= 1'b0;
      flag_snap_q <= 1'b0;
      host_kind_q <= RSP_IDLE;
      eng_kind_q  <= RSP_IDLE;
    end else begin
      if (host_touch) flag_q <= collide;
      flag_snap_q <= flag_q;
      host_kind_q <= host_kind;
      eng_kind_q  <= eng_kind;
    end
  end

  assign flag_word = {{(DATA_W-1){1'b0}}, flag_snap_q};

  assign host_ack = (host_kind_q != RSP_IDLE);
  assign eng_ack  = (eng_kind_q != RSP_IDLE);

  always_comb begin
    case (host_kind_q)
      RSP_MEM:  host_rdata = mem_rd;
      RSP_FLAG: host_rdata = flag_word;
      default:  host_rdata = '0;
    endcase
    case (eng_kind_q)
      RSP_MEM:  eng_rdata = mem_rd;
      RSP_FLAG: eng_rdata = flag_word;
      default:  eng_rdata = '0;
    endcase
  end
endmodule

// File: rtl/csr_collide_arbiter_chk.sv
module csr_collide_arbiter_chk #(
  parameter int ENG_IDX_W = 5,
  parameter int ENGINE_ID = 3,
  parameter int OFS_W = 10,
  parameter int DATA_W = 32,
  parameter logic [OFS_W-1:0] FLAG_OFS = 10'h180,
  localparam int HA_W = ENG_IDX_W + OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_we,
  input logic [HA_W-1:0]   host_addr,
  input logic              host_ack,
  input logic [DATA_W-1:0] host_rdata,
  input logic              eng_valid,
  input logic              eng_ack,
  input logic              flag_q
);
  logic mine, at_flag;
  assign mine    = host_valid && (host_addr[HA_W-1:OFS_W] == ENG_IDX_W'(ENGINE_ID));
  assign at_flag = (host_addr[OFS_W-1:0] == FLAG_OFS);

  p_host_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mine |=> host_ack);

  p_foreign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mine |=> !host_ack);

  p_eng_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |=> eng_ack);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && !at_flag && eng_valid) |=> flag_q);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && !at_flag && !eng_valid) |=> !flag_q);

  p_flag_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mine || at_flag) |=> $stable(flag_q));

  p_drop_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && !at_flag && eng_valid && !host_we) |=> (host_rdata == '0));
endmodule

bind csr_collide_arbiter csr_collide_arbiter_chk #(
  .ENG_IDX_W(ENG_IDX_W), .ENGINE_ID(ENGINE_ID), .OFS_W(OFS_W),
  .DATA_W(DATA_W), .FLAG_OFS(FLAG_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
  .host_addr(host_addr), .host_ack(host_ack), .host_rdata(host_rdata),
  .eng_valid(eng_valid), .eng_ack(eng_ack), .flag_q(flag_q)
);

// File: tb/csr_collide_arbiter_tb_top.sv
module csr_collide_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 3;
  localparam int MY_ID = 5;
  localparam int OW = 10;
  localparam int DW = 32;
  localparam int AW = IW + OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ack;
  logic [DW-1:0] host_rdata;
  logic eng_valid = 1'b0, eng_we = 1'b0;
  logic [OW-1:0] eng_offset = '0;
  logic [DW-1:0] eng_wdata = '0;
  logic eng_ack;
  logic [DW-1:0] eng_rdata;

  int checks = 0;
  int errors = 0;
  logic h_ack_s, e_ack_s;
  logic [DW-1:0] h_rd_s, e_rd_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_collide_arbiter #(.ENG_IDX_W(IW), .ENGINE_ID(MY_ID), .OFS_W(OW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .eng_valid(eng_valid), .eng_we(eng_we), .eng_offset(eng_offset),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
  );

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] haddr(int id, logic [OW-1:0] ofs);
    return {IW'(id), ofs};
  endfunction

  // One request cycle on either or both ports; response sampled next cycle.
  task automatic step(logic hv, logic hwe, logic [AW-1:0] ha, logic [DW-1:0] hwd,
                      logic ev, logic ewe, logic [OW-1:0] eo, logic [DW-1:0] ewd);
    @(negedge clk);
    host_valid = hv; host_we = hwe; host_addr = ha; host_wdata = hwd;
    eng_valid = ev; eng_we = ewe; eng_offset = eo; eng_wdata = ewd;
    @(negedge clk);
    host_valid = 1'b0; eng_valid = 1'b0;
    h_ack_s = host_ack; h_rd_s = host_rdata;
    e_ack_s = eng_ack;  e_rd_s = eng_rdata;
  endtask

  task automatic host_wr(logic [OW-1:0] o, logic [DW-1:0] d);
    step(1'b1, 1'b1, haddr(MY_ID, o), d, 1'b0, 1'b0, '0, '0);
  endtask
  task automatic host_rd(logic [OW-1:0] o);
    step(1'b1, 1'b0, haddr(MY_ID, o), '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    check("R1 host_ack", {31'b0, host_ack}, 32'd0);
    check("R1 eng_ack", {31'b0, eng_ack}, 32'd0);
    host_rd(10'h180);
    check("R1 flag after reset", h_rd_s, 32'd0);
  endtask

  task automatic t_host_rw();
    host_wr(10'h040, 32'hA5A5_0001);
    check("R2 write ack", {31'b0, h_ack_s}, 32'd1);
    host_rd(10'h040);
    check("R2 read ack", {31'b0, h_ack_s}, 32'd1);
    check("R2 read data", h_rd_s, 32'hA5A5_0001);
    host_rd(10'h043);
    check("R11 byte lane alias", h_rd_s, 32'hA5A5_0001);
  endtask

  task automatic t_foreign();
    step(1'b1, 1'b1, haddr(2, 10'h040), 32'hDEAD_BEEF, 1'b0, 1'b0, '0, '0);
    check("R3 no ack for foreign index", {31'b0, h_ack_s}, 32'd0);
    host_rd(10'h040);
    check("R3 word unchanged", h_rd_s, 32'hA5A5_0001);
  endtask

  task automatic t_engine();
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 10'h080, 32'h1234_5678);
    check("R4 eng write ack", {31'b0, e_ack_s}, 32'd1);
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 10'h080, '0);
    check("R4 eng read data", e_rd_s, 32'h1234_5678);
    host_rd(10'h080);
    check("R4 host sees engine write", h_rd_s, 32'h1234_5678);
  endtask

  task automatic t_collide_write();
    step(1'b1, 1'b1, haddr(MY_ID, 10'h040), 32'h0BAD_0BAD, 1'b1, 1'b1, 10'h084, 32'hCAFE_0084);
    check("R4 eng served in collision", {31'b0, e_ack_s}, 32'd1);
    host_rd(10'h180);
    check("R6 flag set", h_rd_s, 32'd1);
    host_rd(10'h180);
    check("R8 flag read leaves flag", h_rd_s, 32'd1);
    host_rd(10'h040);
    check("R5 dropped write not stored", h_rd_s, 32'hA5A5_0001);
    host_rd(10'h180);
    check("R7 flag cleared", h_rd_s, 32'd0);
    host_rd(10'h084);
    check("R4 eng write stored", h_rd_s, 32'hCAFE_0084);
  endtask

  task automatic t_collide_read();
    step(1'b1, 1'b0, haddr(MY_ID, 10'h080), '0, 1'b1, 1'b0, 10'h084, '0);
    check("R9 dropped read acked", {31'b0, h_ack_s}, 32'd1);
    check("R9 dropped read data", h_rd_s, 32'd0);
    check("R4 eng read in collision", e_rd_s, 32'hCAFE_0084);
  endtask

  task automatic t_flag_port();
    // flag is 1 from the collision above
    step(1'b1, 1'b0, haddr(MY_ID, 10'h180), '0, 1'b1, 1'b0, 10'h080, '0);
    check("R8 flag read with engine busy", h_rd_s, 32'd1);
    check("R8 engine served alongside", e_rd_s, 32'h1234_5678);
    host_wr(10'h180, 32'd0);
    host_rd(10'h180);
    check("R8 flag write ignored", h_rd_s, 32'd1);
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 10'h180, '0);
    check("R10 engine reads flag", e_rd_s, 32'd1);
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 10'h180, 32'd0);
    host_rd(10'h180);
    check("R10 engine flag write ignored", h_rd_s, 32'd1);
    host_wr(10'h181, 32'h5151_5151);
    host_rd(10'h180);
    check("R11 exact flag offset only", h_rd_s, 32'd0);
    host_rd(10'h182);
    check("R11 neighbour word stored", h_rd_s, 32'h5151_5151);
  endtask

  task automatic t_retry();
    step(1'b1, 1'b1, haddr(MY_ID, 10'h0C0), 32'h7777_0001, 1'b1, 1'b0, 10'h040, '0);
    host_rd(10'h180);
    check("R6 flag set before retry", h_rd_s, 32'd1);
    host_wr(10'h0C0, 32'h7777_0001);
    host_rd(10'h180);
    check("R7 flag clear after retry", h_rd_s, 32'd0);
    host_rd(10'h0C0);
    check("R2 retried write stored", h_rd_s, 32'h7777_0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_rw();
    t_foreign();
    t_engine();
    t_collide_write();
    t_collide_read();
    t_flag_port();
    t_retry();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule